// File: doc/BRIEF.md
# Selector Channel DMA Controller

This block is a single byte-programmed selector channel. The CPU programs it through a byte-wide I/O port that carries four operations: write data, read data, sense status and output command. The start and end addresses of a memory block are loaded as a stream of bytes shifted through a combined start/end register pair. A command byte then starts the channel. After that, the channel walks the block one byte at a time over a request/acknowledge memory interface, and raises an interrupt request once the last address has been moved.

An `addr_mode` input selects the address format. Plain 16-bit mode uses up to four load bytes. 18-bit banked mode adds a two-bit bank taken from the start command. 20-bit mode uses up to six load bytes. While the channel is running, the CPU can read the current start address back one byte at a time through a decrementing, wrapping byte pointer.

Top module: `selch_top`

## Requirements
- R1: After reset the channel is idle. `mem_req`, `chan_busy` and `chan_irq` are low, both addresses are zero, the readback pointer selects byte 1 and the load byte count is zero.
- R2: `io_op` encoding is 0 write data, 1 read data, 2 sense status and 3 output command. Command byte bits are 6 extended readback, 5 direction (1 = memory to device), 4 start, 3 halt, 2 own status, 1:0 bank. Halt wins over start. A halt clears start and direction, keeps bits 6 and 2, drops a pending `chan_irq`, reloads the readback pointer and zeroes the load byte count.
- R3: In modes 0 and 1, each data write sets start to {start[7:0], end[15:8]} and end to {end[7:0], byte}, both limited to 16 bits. Writes after the fourth since the last halt are ignored.
- R4: In modes 2 and 3, up to six bytes are taken. For bytes one to five, start becomes {start[11:0], end[15:8]} and end becomes {end[7:0], byte}. The sixth byte makes end {end[11:0], byte}. Further bytes are ignored.
- R5: A read returns the start byte chosen by the pointer: 0 selects bits 7:0, 1 selects bits 15:8 and 2 selects bits 19:16 zero-extended. The pointer then decrements. From 0 it reloads to 2 when bit 6 is held and the mode is 2 or 3, and to 1 otherwise. `io_rdata` is zero for write data, for output command and when `io_valid` is low.
- R6: A start command keeps bits 6, 5, 4 and 2. If at most four bytes have been loaded, both addresses are cut to 16 bits and get bank bits 1:0 at positions 17:16 (mode 1 only). The start address is then made even.
- R7: On start, if end is at or below start, end is ORed with 0xFFFF in modes 0 and 1, and with 0xFFFFF in modes 2 and 3.
- R8: In modes 0 and 1, command bits 6 and 2 are forced to zero before the command is decoded.
- R9: Sense status returns 0x08 while the start bit is held. Otherwise it returns 0x00 if own status is selected, and 0x01 (no peripheral status path) if not.
- R10: `mem_req` is high when the start bit is held and `io_valid` is low. `mem_addr` is the start address and `mem_to_dev` is command bit 5. Each cycle with `mem_req` and `mem_ack` both high moves one byte and increments the start address.
- R11: An acknowledged byte at or past the end address raises `chan_irq` and clears start and direction. It leaves the start address on that last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_mode | input | 2 | 0 = 16-bit, 1 = 18-bit banked, 2/3 = 20-bit |
| io_valid | input | 1 | CPU I/O operation this cycle |
| io_op | input | 2 | CPU operation code |
| io_wdata | input | 8 | Data or command byte from the CPU |
| io_rdata | output | 8 | Readback byte or status byte |
| mem_req | output | 1 | Memory byte transfer request |
| mem_to_dev | output | 1 | Transfer direction, 1 = memory to device |
| mem_addr | output | 20 | Current transfer address |
| mem_ack | input | 1 | Memory accepted the requested byte |
| chan_irq | output | 1 | End-of-block interrupt request |
| chan_busy | output | 1 | Channel is running |

## Verification
The bench targets the load sequences past their byte limits. A sequencer that keeps shifting would corrupt the start address read back afterwards. It checks the sixth wide byte, where a design that treats it like the others would move end bits into start. It exercises the pointer wrap with and without extended readback. A wrong reload value returns the top byte where the middle byte belongs, or the reverse. It starts a block whose end lies below its start: without the wrap fix the channel would stop after a single byte. A directed banked transfer counts the exact bytes to the interrupt and checks that start is held on the last address rather than one past it.

// File: rtl/selch_pkg.sv
package selch_pkg;

   typedef enum logic [1:0] {
      IO_WR    = 2'd0,
      IO_RD    = 2'd1,
      IO_SENSE = 2'd2,
      IO_CMD   = 2'd3
   } io_op_e;

   // command byte bit positions
   localparam int CB_EXT  = 6;
   localparam int CB_DIR  = 5;
   localparam int CB_GO   = 4;
   localparam int CB_HALT = 3;
   localparam int CB_OWN  = 2;

   // status byte bit positions
   localparam int ST_BUSY  = 3;
   localparam int ST_NODEV = 0;

   typedef struct packed {
      logic ext;
      logic dir;
      logic go;
      logic own;
   } cmd_t;

endpackage

// File: rtl/selch_cmd_reg.sv
module selch_cmd_reg
   import selch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic halt_stb,
   input  logic start_stb,
   input  logic c_ext,
   input  logic c_dir,
   input  logic c_own,
   input  logic end_evt,
   output cmd_t cmd_q,
   output logic irq_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         irq_q <= 1'b0;
      end else if (halt_stb) begin
         cmd_q.ext <= c_ext;
         cmd_q.own <= c_own;
         cmd_q.go  <= 1'b0;
         cmd_q.dir <= 1'b0;
         irq_q     <= 1'b0;
      end else if (start_stb) begin
         cmd_q.ext <= c_ext;
         cmd_q.own <= c_own;
         cmd_q.go  <= 1'b1;
         cmd_q.dir <= c_dir;
      end else if (end_evt) begin
         cmd_q.go  <= 1'b0;
         cmd_q.dir <= 1'b0;
         irq_q     <= 1'b1;
      end
   end

   AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt && !halt_stb && !start_stb |=> irq_q && !cmd_q.go); // R11
   AST_HALT_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      halt_stb |=> !irq_q && !cmd_q.go && !cmd_q.dir); // R2
   AST_DIR_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q.dir |-> cmd_q.go); // R11

endmodule

// File: rtl/selch_addr_regs.sv
module selch_addr_regs #(
   parameter int ADDR_W       = 20,
   parameter int LOW_W        = 16,
   parameter int BYTE_W       = 8,
   parameter int BANK_W       = 2,
   parameter int NARROW_BYTES = 4,
   parameter int WIDE_BYTES   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic              banked,
   input  logic              halt_stb,
   input  logic              start_stb,
   input  logic [BANK_W-1:0] bank,
   input  logic              wr_stb,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              step_stb,
   output logic [ADDR_W-1:0] sa_q,
   output logic [ADDR_W-1:0] ea_q,
   output logic              end_evt
);

   localparam int CNT_W = $clog2(WIDE_BYTES + 1);
   localparam logic [ADDR_W-1:0] LOW_MASK  = {{(ADDR_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};
   localparam logic [ADDR_W-1:0] FULL_MASK = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BYTE_MASK = {{(ADDR_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
   localparam logic [CNT_W-1:0]  N_LIM     = CNT_W'(NARROW_BYTES);
   localparam logic [CNT_W-1:0]  W_LIM     = CNT_W'(WIDE_BYTES);
   localparam logic [CNT_W-1:0]  W_LAST    = CNT_W'(WIDE_BYTES - 1);

   if (ADDR_W < LOW_W + BANK_W) begin : g_bad_bank
      $error("selch_addr_regs: ADDR_W too small for bank field");
   end
   if (WIDE_BYTES <= NARROW_BYTES) begin : g_bad_cnt
      $error("selch_addr_regs: WIDE_BYTES must exceed NARROW_BYTES");
   end

   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [ADDR_W-1:0] sa_d, ea_d, sa_t, ea_t, byte_ext, bank_ext;

   assign byte_ext = {{(ADDR_W-BYTE_W){1'b0}}, wr_byte};
   assign bank_ext = banked ? {{(ADDR_W-LOW_W-BANK_W){1'b0}}, bank, {LOW_W{1'b0}}} : '0;

   always_comb begin
      sa_d    = sa_q;
      ea_d    = ea_q;
      cnt_d   = cnt_q;
      sa_t    = sa_q;
      ea_t    = ea_q;
      end_evt = 1'b0;
      if (halt_stb) begin
         cnt_d = '0;
      end else if (start_stb) begin
         if (cnt_q <= N_LIM) begin
            sa_t = (sa_q & LOW_MASK) | bank_ext;
            ea_t = (ea_q & LOW_MASK) | bank_ext;
         end
         sa_t[0] = 1'b0;
         if (ea_t <= sa_t) begin
            ea_t = ea_t | (wide ? FULL_MASK : LOW_MASK);
         end
         sa_d = sa_t;
         ea_d = ea_t;
      end else if (wr_stb) begin
         if (!wide) begin
            if (cnt_q < N_LIM) begin
               sa_d  = ((sa_q << BYTE_W) & LOW_MASK) | ((ea_q >> BYTE_W) & BYTE_MASK);
               ea_d  = ((ea_q << BYTE_W) & LOW_MASK) | byte_ext;
               cnt_d = cnt_q + CNT_W'(1);
            end
         end else if (cnt_q < W_LIM) begin
            if (cnt_q != W_LAST) begin
               sa_d = (sa_q << BYTE_W) | ((ea_q >> BYTE_W) & BYTE_MASK);
               ea_d = ((ea_q & BYTE_MASK) << BYTE_W) | byte_ext;
            end else begin
               ea_d = (ea_q << BYTE_W) | byte_ext;
            end
            cnt_d = cnt_q + CNT_W'(1);
         end
      end else if (step_stb) begin
         if (sa_q >= ea_q) begin
            end_evt = 1'b1;
         end else begin
            sa_d = sa_q + ADDR_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sa_q  <= '0;
         ea_q  <= '0;
         cnt_q <= '0;
      end else begin
         sa_q  <= sa_d;
         ea_q  <= ea_d;
         cnt_q <= cnt_d;
      end
   end

   AST_LOAD_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= W_LIM); // R4
   AST_NARROW_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && !halt_stb && !start_stb && !wide && cnt_q < N_LIM
      |=> (sa_q & ~LOW_MASK) == '0 && (ea_q & ~LOW_MASK) == '0); // R3
   AST_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb && !halt_stb |=> !sa_q[0]); // R6
   AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb && !halt_stb && cnt_q <= N_LIM |=> ea_q > sa_q); // R7
   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      step_stb && !halt_stb && !start_stb && !wr_stb && sa_q < ea_q
      |=> sa_q == $past(sa_q) + ADDR_W'(1)); // R10
   AST_END_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt |=> $stable(sa_q)); // R11

endmodule

// File: rtl/selch_rd_ptr.sv
module selch_rd_ptr #(
   parameter int PTR_W   = 2,
   parameter int STD_TOP = 1,
   parameter int EXT_TOP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic             reload_stb,
   input  logic             ext_now,
   input  logic             ext_new,
   output logic [PTR_W-1:0] ptr_q
);

   localparam logic [PTR_W-1:0] P_STD = PTR_W'(STD_TOP);
   localparam logic [PTR_W-1:0] P_EXT = PTR_W'(EXT_TOP);

   if (EXT_TOP >= (1 << PTR_W) || STD_TOP > EXT_TOP) begin : g_bad_ptr
      $error("selch_rd_ptr: pointer limits do not fit");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= P_STD;
      end else if (reload_stb) begin
         ptr_q <= ext_new ? P_EXT : P_STD;
      end else if (rd_stb) begin
         if (ptr_q == '0) ptr_q <= ext_now ? P_EXT : P_STD;
         else             ptr_q <= ptr_q - PTR_W'(1);
      end
   end

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= P_EXT); // R5
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !reload_stb && ptr_q == '0 |=> ptr_q == P_STD || ptr_q == P_EXT); // R5

endmodule

// File: rtl/selch_top.sv
module selch_top
   import selch_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int LOW_W        = 16,
   parameter int BYTE_W       = 8,
   parameter int BANK_W       = 2,
   parameter int NARROW_BYTES = 4,
   parameter int WIDE_BYTES   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_mode,
   input  logic              io_valid,
   input  logic [1:0]        io_op,
   input  logic [BYTE_W-1:0] io_wdata,
   output logic [BYTE_W-1:0] io_rdata,
   output logic              mem_req,
   output logic              mem_to_dev,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic              chan_irq,
   output logic              chan_busy
);

   localparam int LANES   = (ADDR_W + BYTE_W - 1) / BYTE_W;
   localparam int PAD_W   = LANES * BYTE_W;
   localparam int PTR_W   = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int STD_TOP = LOW_W / BYTE_W - 1;
   localparam int EXT_TOP = LANES - 1;

   if (BYTE_W <= CB_EXT || BANK_W > CB_OWN) begin : g_bad_byte
      $error("selch_top: command byte fields do not fit");
   end
   if (ADDR_W > LOW_W + BYTE_W) begin : g_bad_addr
      $error("selch_top: ADDR_W exceeds load stream reach");
   end

   io_op_e            op;
   logic              wide, banked;
   logic              c_ext, c_own, c_dir, c_go, c_halt;
   logic              is_cmd, halt_stb, start_stb, wr_stb, rd_stb, step_stb;
   logic              end_evt, irq_q;
   logic [BANK_W-1:0] c_bank;
   cmd_t              cmd_q;
   logic [ADDR_W-1:0] sa_q, ea_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [PAD_W-1:0]  sa_pad;
   logic [BYTE_W-1:0] lane_byte [LANES];
   logic [BYTE_W-1:0] rd_byte, stat_byte;

   assign op     = io_op_e'(io_op);
   assign wide   = addr_mode[1];
   assign banked = (addr_mode == 2'd1);

   // narrow modes lose the extended bits before decode
   assign c_ext  = io_wdata[CB_EXT] & wide;
   assign c_own  = io_wdata[CB_OWN] & wide;
   assign c_dir  = io_wdata[CB_DIR];
   assign c_go   = io_wdata[CB_GO];
   assign c_halt = io_wdata[CB_HALT];
   assign c_bank = io_wdata[BANK_W-1:0];

   assign is_cmd    = io_valid && (op == IO_CMD);
   assign halt_stb  = is_cmd && c_halt;
   assign start_stb = is_cmd && !c_halt && c_go;
   assign wr_stb    = io_valid && (op == IO_WR);
   assign rd_stb    = io_valid && (op == IO_RD);
   assign mem_req   = cmd_q.go && !io_valid;
   assign step_stb  = mem_req && mem_ack;

   selch_cmd_reg u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt_stb  (halt_stb),
      .start_stb (start_stb),
      .c_ext     (c_ext),
      .c_dir     (c_dir),
      .c_own     (c_own),
      .end_evt   (end_evt),
      .cmd_q     (cmd_q),
      .irq_q     (irq_q)
   );

   selch_addr_regs #(
      .ADDR_W       (ADDR_W),
      .LOW_W        (LOW_W),
      .BYTE_W       (BYTE_W),
      .BANK_W       (BANK_W),
      .NARROW_BYTES (NARROW_BYTES),
      .WIDE_BYTES   (WIDE_BYTES)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide      (wide),
      .banked    (banked),
      .halt_stb  (halt_stb),
      .start_stb (start_stb),
      .bank      (c_bank),
      .wr_stb    (wr_stb),
      .wr_byte   (io_wdata),
      .step_stb  (step_stb),
      .sa_q      (sa_q),
      .ea_q      (ea_q),
      .end_evt   (end_evt)
   );

   selch_rd_ptr #(
      .PTR_W   (PTR_W),
      .STD_TOP (STD_TOP),
      .EXT_TOP (EXT_TOP)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_stb     (rd_stb),
      .reload_stb (halt_stb),
      .ext_now    (cmd_q.ext && wide),
      .ext_new    (c_ext),
      .ptr_q      (ptr_q)
   );

   assign sa_pad = PAD_W'(sa_q);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_byte[l] = sa_pad[l*BYTE_W +: BYTE_W];
   end

   always_comb begin
      rd_byte = '0;
      for (int l = 0; l < LANES; l++) begin
         if (ptr_q == PTR_W'(l)) rd_byte = lane_byte[l];
      end
   end

   always_comb begin
      stat_byte = '0;
      if (cmd_q.go)        stat_byte[ST_BUSY]  = 1'b1;
      else if (!cmd_q.own) stat_byte[ST_NODEV] = 1'b1;
   end

   always_comb begin
      io_rdata = '0;
      if (io_valid && op == IO_RD)         io_rdata = rd_byte;
      else if (io_valid && op == IO_SENSE) io_rdata = stat_byte;
   end

   assign mem_addr   = sa_q;
   assign mem_to_dev = cmd_q.dir;
   assign chan_irq   = irq_q;
   assign chan_busy  = cmd_q.go;

   AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> !mem_req || $stable(mem_addr)); // R10
   AST_IRQ_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_irq) |-> !chan_busy); // R11

endmodule

// File: tb/selch_top_tb_top.sv
module selch_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode;
   logic        io_valid;
   logic [1:0]  io_op;
   logic [7:0]  io_wdata;
   logic        mem_ack;
   logic [7:0]  io_rdata;
   logic        mem_req, mem_to_dev, chan_irq, chan_busy;
   logic [19:0] mem_addr;

   always #5 clk = ~clk;

   selch_top dut_i (
      .clk(clk), .rst_n(rst_n), .addr_mode(mode), .io_valid(io_valid),
      .io_op(io_op), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mem_req(mem_req), .mem_to_dev(mem_to_dev), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .chan_irq(chan_irq), .chan_busy(chan_busy)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference state built from the requirements
   logic [19:0] m_sa, m_ea;
   int          m_cnt, m_ptr;
   logic        m_ext, m_dir, m_go, m_own, m_irq;

   logic [7:0]  s_rdata;
   logic [19:0] s_addr;
   logic        s_req, s_dir, s_irq, s_busy;

   task automatic mdl_reset();
      m_sa = '0; m_ea = '0; m_cnt = 0; m_ptr = 1;
      m_ext = 0; m_dir = 0; m_go = 0; m_own = 0; m_irq = 0;
   endtask

   function automatic logic [7:0] mdl_rbyte();
      case (m_ptr)
         0: return m_sa[7:0];
         1: return m_sa[15:8];
         default: return {4'h0, m_sa[19:16]};
      endcase
   endfunction

   function automatic logic [7:0] mdl_rdata(input logic v, input logic [1:0] op);
      if (!v) return 8'h00;
      if (op == 2'd1) return mdl_rbyte();
      if (op == 2'd2) return m_go ? 8'h08 : (m_own ? 8'h00 : 8'h01);
      return 8'h00;
   endfunction

   task automatic mdl_apply(input logic v, input logic [1:0] op, input logic [7:0] d, input logic ack);
      logic wide, banked;
      logic [7:0] c;
      logic [19:0] s, e, bk;
      wide = mode[1];
      banked = (mode == 2'd1);
      if (v) begin
         case (op)
            2'd0: begin
               if (!wide) begin
                  if (m_cnt < 4) begin
                     m_sa = {4'h0, m_sa[7:0], m_ea[15:8]};
                     m_ea = {4'h0, m_ea[7:0], d};
                     m_cnt++;
                  end
               end else if (m_cnt < 6) begin
                  if (m_cnt != 5) begin
                     m_sa = {m_sa[11:0], m_ea[15:8]};
                     m_ea = {4'h0, m_ea[7:0], d};
                  end else m_ea = {m_ea[11:0], d};
                  m_cnt++;
               end
            end
            2'd1: begin
               if (m_ptr == 0) m_ptr = (m_ext && wide) ? 2 : 1;
               else m_ptr--;
            end
            2'd3: begin
               c = wide ? d : (d & 8'hBB);
               if (c[3]) begin
                  m_ext = c[6]; m_own = c[2]; m_go = 0; m_dir = 0; m_irq = 0;
                  m_ptr = (c[6] && wide) ? 2 : 1; m_cnt = 0;
               end else if (c[4]) begin
                  m_ext = c[6]; m_own = c[2]; m_go = 1; m_dir = c[5];
                  s = m_sa; e = m_ea;
                  if (m_cnt <= 4) begin
                     bk = banked ? {2'b00, c[1:0], 16'h0000} : 20'h0;
                     s = {4'h0, s[15:0]} | bk;
                     e = {4'h0, e[15:0]} | bk;
                  end
                  s[0] = 1'b0;
                  if (e <= s) e = e | (wide ? 20'hFFFFF : 20'h0FFFF);
                  m_sa = s; m_ea = e;
               end
            end
            default: ;
         endcase
      end else if (ack && m_go) begin
         if (m_sa >= m_ea) begin
            m_irq = 1; m_go = 0; m_dir = 0;
         end else m_sa = m_sa + 20'd1;
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // one cycle: drive at negedge, compare against the model, then clock
   task automatic cyc(input logic v, input logic [1:0] op, input logic [7:0] d, input logic ack);
      logic [7:0] e_rd;
      logic bad;
      io_valid = v; io_op = op; io_wdata = d; mem_ack = ack;
      #1;
      s_rdata = io_rdata; s_req = mem_req; s_addr = mem_addr;
      s_dir = mem_to_dev; s_irq = chan_irq; s_busy = chan_busy;
      e_rd = mdl_rdata(v, op);
      bad = 0;
      n_tests++;
      if (s_rdata !== e_rd) begin
         bad = 1;
         $display("FAIL %s rdata: got %0h expected %0h", (op == 2'd2) ? "R9" : "R5", s_rdata, e_rd);
      end
      if (s_req !== (m_go && !v) || (s_req && s_addr !== m_sa) || s_dir !== m_dir) begin
         bad = 1;
         $display("FAIL R10 mem: got req %0b addr %0h dir %0b expected req %0b addr %0h dir %0b",
                  s_req, s_addr, s_dir, m_go && !v, m_sa, m_dir);
      end
      if (s_irq !== m_irq || s_busy !== m_go) begin
         bad = 1;
         $display("FAIL R11 irq/busy: got %0b/%0b expected %0b/%0b", s_irq, s_busy, m_irq, m_go);
      end
      if (bad) n_fail++;
      @(posedge clk);
      mdl_apply(v, op, d, ack);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] md);
      @(negedge clk);
      rst_n = 0; mode = md; io_valid = 0; io_op = 0; io_wdata = 0; mem_ack = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      mdl_reset();
   endtask

   task automatic wr(input logic [7:0] d); cyc(1, 2'd0, d, 0); endtask
   task automatic rd(input logic [7:0] exp, input string tag);
      cyc(1, 2'd1, 8'h00, 0);
      chk(tag, {24'h0, s_rdata}, {24'h0, exp});
   endtask
   task automatic cmd(input logic [7:0] d); cyc(1, 2'd3, d, 0); endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 0; mode = 0; io_valid = 0; io_op = 0; io_wdata = 0; mem_ack = 0;

      // R1: reset state
      do_reset(2'd0);
      cyc(0, 2'd0, 8'h00, 1);
      chk("R1 busy", {31'h0, s_busy}, 0);
      chk("R1 irq", {31'h0, s_irq}, 0);
      chk("R1 req", {31'h0, s_req}, 0);
      chk("R1 addr", {12'h0, s_addr}, 0);

      // R3 narrow load, fifth byte ignored; R1 pointer starts at byte 1; R5 wrap
      do_reset(2'd0);
      wr(8'hAB); wr(8'hCD); wr(8'h00); wr(8'h00); wr(8'h9A);
      rd(8'hAB, "R1 first readback byte");
      rd(8'hCD, "R3 low byte");
      rd(8'hAB, "R5 narrow wrap");

      // R4 wide load of six bytes, seventh ignored; R2 halt with ext; R5 ext wrap
      do_reset(2'd2);
      cmd(8'h48);
      wr(8'h01); wr(8'h23); wr(8'h45); wr(8'h67); wr(8'h89); wr(8'hAB); wr(8'hCD);
      rd(8'h01, "R4 top byte");
      rd(8'h23, "R4 mid byte");
      rd(8'h45, "R4 low byte");
      rd(8'h01, "R5 ext wrap");

      // R6 even start, R9 status while running and with own status
      cmd(8'h50);
      cyc(1, 2'd2, 8'h00, 0);
      chk("R9 busy status", {24'h0, s_rdata}, 32'h08);
      cmd(8'h4C);
      cyc(1, 2'd2, 8'h00, 0);
      chk("R9 own status", {24'h0, s_rdata}, 32'h00);
      rd(8'h01, "R6 top byte kept");
      rd(8'h23, "R6 mid byte kept");
      rd(8'h44, "R6 forced even");
      cmd(8'h08);
      cyc(1, 2'd2, 8'h00, 0);
      chk("R9 no own status", {24'h0, s_rdata}, 32'h01);

      // R6 bank, R10 stepping, R11 end of block
      do_reset(2'd1);
      cmd(8'h08);
      wr(8'h00); wr(8'h11); wr(8'h00); wr(8'h15);
      cmd(8'h13);
      for (int i = 0; i < 6; i++) begin
         cyc(0, 2'd0, 8'h00, 1);
         chk("R10 banked addr", {12'h0, s_addr}, 32'h30010 + i);
         chk("R10 direction", {31'h0, s_dir}, 0);
      end
      cyc(0, 2'd0, 8'h00, 1);
      chk("R11 irq raised", {31'h0, s_irq}, 1);
      chk("R11 idle", {31'h0, s_busy}, 0);
      rd(8'h00, "R11 held mid byte");
      rd(8'h15, "R11 held last addr");
      cmd(8'h08);
      cyc(0, 2'd0, 8'h00, 0);
      chk("R2 halt drops irq", {31'h0, s_irq}, 0);

      // R7 wrap when end below start; R10 direction
      do_reset(2'd0);
      wr(8'h00); wr(8'h20); wr(8'h00); wr(8'h10);
      cmd(8'h30);
      cyc(0, 2'd0, 8'h00, 1);
      chk("R10 first addr", {12'h0, s_addr}, 32'h20);
      chk("R10 mem to dev", {31'h0, s_dir}, 1);
      cyc(0, 2'd0, 8'h00, 1);
      cyc(0, 2'd0, 8'h00, 0);
      chk("R7 still running", {31'h0, s_busy}, 1);
      chk("R7 addr", {12'h0, s_addr}, 32'h22);

      // R8 narrow mode drops ext bit
      do_reset(2'd0);
      cmd(8'h48);
      wr(8'hAB); wr(8'hCD); wr(8'h00); wr(8'h00);
      mode = 2'd2;
      rd(8'hAB, "R8 ptr after halt");
      rd(8'hCD, "R8 low byte");
      rd(8'hAB, "R8 ext bit masked");

      // random traffic against the reference model
      for (int md = 0; md < 3; md++) begin
         do_reset(md[1:0]);
         for (int k = 0; k < 3000; k++) begin
            int r;
            logic [7:0] b;
            r = $urandom % 100;
            b = 8'($urandom);
            if (r < 30)      cyc(1, 2'd0, b, 0);
            else if (r < 45) cyc(1, 2'd1, b, 0);
            else if (r < 52) cyc(1, 2'd2, b, 0);
            else if (r < 65) begin
               int s;
               s = $urandom % 10;
               if (s < 4)      cyc(1, 2'd3, (b & 8'hF7) | 8'h08, 0);
               else if (s < 8) cyc(1, 2'd3, (b & 8'hE7) | 8'h10, 0);
               else            cyc(1, 2'd3, b, 0);
            end else cyc(0, 2'd0, b, ($urandom % 4) != 0);
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule